// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block runs the control side of loading a programmable device over a slave-serial link. A processor starts a load by writing to one fixed bus address. The block then pulls the active-low program line down long enough to reset the target's configuration logic. It releases the line, waits out the target's post-reset delay and waits for the target's ready line (INIT) to go high. Only then does it let a separate bit streamer send data.

While data flows, and after the streamer reports that the last bit has gone, the block watches INIT and DONE. A drop of INIT at that point means the target found a CRC error. A rise of DONE means the load succeeded. A DONE that never arrives, or an INIT held low for too long before loading, ends the attempt as a timeout. Another write to the trigger address from the finished or failed state starts the whole sequence again.

The streamer handshake works like a valid/ready pair with the sequencer as the permitting side. `strm_en` is a level that gives the streamer permission to send. The streamer must stop sending in the cycle after `strm_en` falls. `strm_en` falls either on a CRC error or after the streamer finishes. The streamer raises `strm_fin` for at least one cycle after its last bit. `strm_fin` counts only while `strm_en` is high. Timing limits are given in nanoseconds and rounded up to whole clock cycles.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After reset, `prog_n` is 1 and `strm_en`, `busy`, `cfg_ok`, `crc_err` and `to_err` are all 0.
- R2: A sequence starts only on a cycle with `bus_wr`=1 and `bus_addr`=TRIG_ADDR. A write to another address, or a read (`bus_wr`=0) of TRIG_ADDR, leaves `prog_n` high and `busy` low.
- R3: After a trigger, `prog_n` is low for exactly PROG_CYC = ceil(PROG_MIN_NS/CLK_PERIOD_NS) consecutive cycles (38 with the defaults).
- R4: When `init_i` is already high, `strm_en` rises exactly DLY_CYC = ceil(INIT_DLY_NS/CLK_PERIOD_NS) cycles after `prog_n` rises (63 with the defaults). It never rises sooner.
- R5: When `init_i` stays low past DLY_CYC, `strm_en` rises within two cycles after `init_i` goes high, and never while `init_i` is low.
- R6: If `init_i` is still low INIT_HOLD_CYC cycles after `prog_n` rises, the sequence ends with `to_err`=1 and `busy`=0, exactly INIT_HOLD_CYC cycles after the release. `strm_en` is never raised in that attempt.
- R7: A low `init_i` while streaming, or while waiting for DONE, ends the sequence in the next cycle with `crc_err`=1, `strm_en`=0 and `busy`=0.
- R8: `strm_en` stays high until `strm_fin` is seen. It is low in the cycle after `strm_fin`.
- R9: `done_i` high after the streamer finished gives `cfg_ok`=1 in the next cycle. At most one of `cfg_ok`, `crc_err` and `to_err` is high at a time.
- R10: Without `done_i`, the block sets `to_err` exactly DONE_TO_CYC cycles after it enters the wait that follows `strm_fin` (200 with the defaults).
- R11: A trigger while `busy` is high is ignored and does not lengthen the program pulse. A trigger from the success or error state clears all status and starts a new program pulse.
- R12: `busy` is high from the program pulse until the sequence ends in success or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Processor bus address |
| bus_wr | input | 1 | Processor write strobe |
| prog_n | output | 1 | Active-low reset of the target's configuration logic |
| init_i | input | 1 | Target ready line; low means reset still in progress or CRC error |
| done_i | input | 1 | Target configuration-complete line |
| strm_en | output | 1 | Permission for the bit streamer to send |
| strm_fin | input | 1 | Streamer reports that the last bit has been sent |
| busy | output | 1 | A sequence is in progress |
| cfg_ok | output | 1 | The last sequence succeeded |
| crc_err | output | 1 | The last sequence ended in a CRC error |
| to_err | output | 1 | The last sequence timed out (INIT held low or DONE missing) |

## Verification
The bench measures the program pulse and the release-to-enable gap to the exact cycle. A design that rounds the nanosecond limits down, or opens streaming as soon as INIT rises, gets a count that is off. It holds INIT low past the post-reset delay and past the hold limit. This catches a design that ignores INIT, never gives up, or gives up too early. It drops INIT during streaming and after the streamer finishes, lets DONE never arrive, and retriggers both mid-pulse and from the terminal states. These cases expose a stale status flag, a pulse restarted by a busy-time write, or a timeout counted from the wrong point.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_WINIT = 3'd2,
    ST_STRM  = 3'd3,
    ST_WDONE = 3'd4,
    ST_OK    = 3'd5,
    ST_ERR   = 3'd6
  } seq_state_e;

  // whole clock cycles covering a nanosecond minimum
  function automatic int cyc_ceil(input int ns, input int per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cfg_trig_decode.sv
module cfg_trig_decode #(
  parameter int               ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output logic              hit_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= bus_wr && (bus_addr == TRIG_ADDR);
  end

  AST_HIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(bus_wr)); // R2

endmodule

// File: rtl/cfg_step_timer.sv
module cfg_step_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int               ADDR_W        = 32,
  parameter logic [ADDR_W-1:0] TRIG_ADDR     = 'h0000_4C00,
  parameter int               CLK_PERIOD_NS = 8,
  parameter int               PROG_MIN_NS   = 300,
  parameter int               INIT_DLY_NS   = 500,
  parameter int               INIT_HOLD_CYC = 400,
  parameter int               DONE_TO_CYC   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output logic              prog_n,
  input  logic              init_i,
  input  logic              done_i,
  output logic              strm_en,
  input  logic              strm_fin,
  output logic              busy,
  output logic              cfg_ok,
  output logic              crc_err,
  output logic              to_err
);

  localparam int PROG_CYC = cyc_ceil(PROG_MIN_NS, CLK_PERIOD_NS);
  localparam int DLY_CYC  = cyc_ceil(INIT_DLY_NS, CLK_PERIOD_NS);
  localparam int CNT_MAX  = max3(PROG_CYC, max3(DLY_CYC, INIT_HOLD_CYC, 1), DONE_TO_CYC);
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(INIT_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] DONE_LAST = CNT_W'(DONE_TO_CYC - 1);

  seq_state_e       state, nxt;
  logic             hit_q;
  logic [CNT_W-1:0] cnt;
  logic             set_crc, set_to;
  logic             crc_q, to_q;

  cfg_trig_decode #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .hit_q   (hit_q)
  );

  cfg_step_timer #(
    .CNT_W(CNT_W)
  ) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (nxt != state),
    .cnt  (cnt)
  );

  always_comb begin
    nxt     = state;
    set_crc = 1'b0;
    set_to  = 1'b0;
    unique case (state)
      ST_IDLE, ST_OK, ST_ERR: begin
        if (hit_q) nxt = ST_PROG;
      end
      ST_PROG: begin
        if (cnt == PROG_LAST) nxt = ST_WINIT;
      end
      ST_WINIT: begin
        if (init_i && cnt >= DLY_LAST) begin
          nxt = ST_STRM;
        end else if (!init_i && cnt >= HOLD_LAST) begin
          nxt    = ST_ERR;
          set_to = 1'b1;
        end
      end
      ST_STRM: begin
        if (!init_i) begin
          nxt     = ST_ERR;
          set_crc = 1'b1;
        end else if (strm_fin) begin
          nxt = ST_WDONE;
        end
      end
      ST_WDONE: begin
        if (!init_i) begin
          nxt     = ST_ERR;
          set_crc = 1'b1;
        end else if (done_i) begin
          nxt = ST_OK;
        end else if (cnt == DONE_LAST) begin
          nxt    = ST_ERR;
          set_to = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      crc_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == ST_PROG) begin
        crc_q <= 1'b0;
        to_q  <= 1'b0;
      end else begin
        if (set_crc) crc_q <= 1'b1;
        if (set_to)  to_q  <= 1'b1;
      end
    end
  end

  assign prog_n  = (state != ST_PROG);
  assign strm_en = (state == ST_STRM);
  assign busy    = (state == ST_PROG) || (state == ST_WINIT) ||
                   (state == ST_STRM) || (state == ST_WDONE);
  assign cfg_ok  = (state == ST_OK);
  assign crc_err = crc_q;
  assign to_err  = to_q;

  // run length of the low program pulse, kept for the width check
  logic [CNT_W-1:0] prog_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           prog_run <= '0;
    else if (prog_n)                      prog_run <= '0;
    else if (prog_run != {CNT_W{1'b1}})   prog_run <= prog_run + 1'b1;
  end

  AST_PROG_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> ($past(prog_run) >= CNT_W'(PROG_CYC - 1))); // R3

  AST_STRM_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strm_en) |-> ($past(prog_n) && $past(init_i))); // R5

  AST_FIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_en && strm_fin && init_i) |=> !strm_en); // R8

  AST_CRC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_en && !init_i) |=> (crc_err && !strm_en)); // R7

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cfg_ok, crc_err, to_err}) <= 1); // R9

  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!crc_err && !to_err)); // R11

endmodule

// File: tb/cfg_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_tb_top;

  localparam int          ADDR_W = 32;
  localparam logic [31:0] TRIG   = 32'h0000_4C00;
  localparam int          PER    = 8;
  localparam int          PROG_CYC = (300 + PER - 1) / PER;
  localparam int          DLY_CYC  = (500 + PER - 1) / PER;
  localparam int          HOLD_CYC = 400;
  localparam int          DTO_CYC  = 200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              prog_n;
  logic              init_i = 1'b0;
  logic              done_i = 1'b0;
  logic              strm_en;
  logic              strm_fin = 1'b0;
  logic              busy, cfg_ok, crc_err, to_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // target model controls
  int init_hold = 0;
  int rel = 0;
  bit crc_drop = 0;

  always #4 clk = ~clk;

  cfg_seq_ctrl #(
    .ADDR_W(ADDR_W), .TRIG_ADDR(TRIG), .CLK_PERIOD_NS(PER),
    .PROG_MIN_NS(300), .INIT_DLY_NS(500),
    .INIT_HOLD_CYC(HOLD_CYC), .DONE_TO_CYC(DTO_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .prog_n(prog_n), .init_i(init_i), .done_i(done_i),
    .strm_en(strm_en), .strm_fin(strm_fin), .busy(busy),
    .cfg_ok(cfg_ok), .crc_err(crc_err), .to_err(to_err)
  );

  // simple target: INIT low while program is low, rises init_hold cycles after release
  always @(negedge clk) begin
    if (!prog_n) begin
      init_i = 1'b0;
      rel    = 0;
    end else if (crc_drop) begin
      init_i = 1'b0;
    end else if (!init_i) begin
      if (rel >= init_hold) init_i = 1'b1;
      else                  rel = rel + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic trigger(input logic [ADDR_W-1:0] a, input logic wr);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = wr;
    @(negedge clk);
    bus_wr   = 1'b0;
    bus_addr = '0;
  endtask

  task automatic wait_prog_low();
    for (int i = 0; i < 10 && prog_n; i++) @(negedge clk);
  endtask

  // returns the number of low cycles; ends at first negedge with prog_n high
  task automatic count_prog_low(output int n);
    n = 0;
    while (!prog_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_to_stream();
    int n;
    done_i = 1'b0;
    trigger(TRIG, 1'b1);
    wait_prog_low();
    count_prog_low(n);
    for (int i = 0; i < 2000 && !strm_en; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 prog_n", int'(prog_n), 1);
    chk("R1 strm_en", int'(strm_en), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 status", int'({cfg_ok, crc_err, to_err}), 0);
  endtask

  task automatic t_decode();
    trigger(TRIG + 32'h4, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2 wrong addr prog_n", int'(prog_n), 1);
    chk("R2 wrong addr busy", int'(busy), 0);
    trigger(TRIG, 1'b0);
    repeat (4) @(negedge clk);
    chk("R2 read prog_n", int'(prog_n), 1);
    chk("R2 read busy", int'(busy), 0);
  endtask

  task automatic t_normal();
    int n, m;
    init_hold = 0;
    done_i = 1'b0;
    trigger(TRIG, 1'b1);
    wait_prog_low();
    chk("R12 busy in pulse", int'(busy), 1);
    count_prog_low(n);
    chk("R3 pulse width", n, PROG_CYC);
    m = 0;
    while (!strm_en && m < 1000) begin
      m++;
      @(negedge clk);
    end
    chk("R4 release to enable", m, DLY_CYC);
    repeat (20) @(negedge clk);
    chk("R8 enable held", int'(strm_en), 1);
    strm_fin = 1'b1;
    @(negedge clk);
    strm_fin = 1'b0;
    chk("R8 enable drops", int'(strm_en), 0);
    chk("R12 busy awaiting done", int'(busy), 1);
    repeat (5) @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    chk("R9 ok", int'(cfg_ok), 1);
    chk("R9 no error", int'({crc_err, to_err}), 0);
    chk("R12 idle after ok", int'(busy), 0);
  endtask

  task automatic t_retrig();
    int n;
    init_hold = 0;
    trigger(TRIG, 1'b1);
    done_i = 1'b0;
    wait_prog_low();
    chk("R11 restart clears ok", int'(cfg_ok), 0);
    n = 0;
    while (!prog_n && n < 1000) begin
      n++;
      if (n == 5) begin bus_addr = TRIG; bus_wr = 1'b1; end
      if (n == 6) begin bus_addr = '0;   bus_wr = 1'b0; end
      @(negedge clk);
    end
    chk("R11 busy trigger ignored", n, PROG_CYC);
    for (int i = 0; i < 200 && !strm_en; i++) @(negedge clk);
    strm_fin = 1'b1;
    @(negedge clk);
    strm_fin = 1'b0;
    done_i = 1'b1;
    @(negedge clk);
    chk("R9 ok after retrigger", int'(cfg_ok), 1);
  endtask

  task automatic t_crc_stream();
    init_hold = 0;
    run_to_stream();
    repeat (3) @(negedge clk);
    crc_drop = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 crc in stream", int'(crc_err), 1);
    chk("R7 enable off", int'(strm_en), 0);
    chk("R7 not busy", int'(busy), 0);
    crc_drop = 1'b0;
  endtask

  task automatic t_crc_wait_done();
    run_to_stream();
    chk("R11 restart clears crc", int'(crc_err), 0);
    strm_fin = 1'b1;
    @(negedge clk);
    strm_fin = 1'b0;
    repeat (3) @(negedge clk);
    crc_drop = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 crc after finish", int'(crc_err), 1);
    chk("R7 no ok", int'(cfg_ok), 0);
    crc_drop = 1'b0;
  endtask

  task automatic t_done_timeout();
    run_to_stream();
    strm_fin = 1'b1;
    @(negedge clk);
    strm_fin = 1'b0;
    repeat (DTO_CYC - 1) @(negedge clk);
    chk("R10 not yet timed out", int'(to_err), 0);
    chk("R10 still busy", int'(busy), 1);
    @(negedge clk);
    chk("R10 done timeout", int'(to_err), 1);
  endtask

  task automatic t_init_late();
    int n, m;
    init_hold = 100;
    done_i = 1'b0;
    trigger(TRIG, 1'b1);
    wait_prog_low();
    count_prog_low(n);
    m = 0;
    while (!strm_en && m < 1000) begin
      m++;
      @(negedge clk);
    end
    chk("R5 waits for ready", int'(m >= init_hold && m <= init_hold + 2), 1);
    chk("R5 ready seen", int'(init_i), 1);
    strm_fin = 1'b1;
    @(negedge clk);
    strm_fin = 1'b0;
    done_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_init_stuck();
    int n, m;
    bit seen_en;
    init_hold = 100000;
    done_i = 1'b0;
    trigger(TRIG, 1'b1);
    wait_prog_low();
    chk("R11 restart clears ok again", int'(cfg_ok), 0);
    count_prog_low(n);
    m = 0;
    seen_en = 0;
    while (busy && m < 2000) begin
      if (strm_en) seen_en = 1;
      m++;
      @(negedge clk);
    end
    chk("R6 hold limit", m, HOLD_CYC);
    chk("R6 timeout flag", int'(to_err), 1);
    chk("R6 never enabled", int'(seen_en), 0);
    init_hold = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_normal();
    t_retrig();
    t_crc_stream();
    t_crc_wait_done();
    t_done_timeout();
    t_init_late();
    t_init_stuck();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule